// File: doc/BRIEF.md
# Guest System-Register Access Trap Decoder

This block sits beside a processor's system-register access path and decides, for every coprocessor register access a guest attempts, whether the access proceeds, is handed to the hypervisor, or raises an undefined-instruction fault. An access is described by its four encoding fields (opc1, CRn, CRm, opc2), a write flag, the current exception level and a non-secure flag. The verdict comes back as two registered flags, trap and undefined, together with a response strobe one clock after the request strobe.

The block also holds the 32-bit virtualization control word that drives these decisions. That word is itself a system register at encoding opc1=4, CRn=1, CRm=1, opc2=0. It is read and written through the same access port from the hypervisor level (EL2) or from the monitor level (EL3) when the non-secure flag is set. Read data is returned on the response. A write changes the verdicts of all later accesses, beginning with the access issued in the next cycle.

Top module: `guest_sysreg_trap`

## Requirements
- R1: Every cycle with acc_valid high gives exactly one cycle of rsp_valid on the next clock. rsp_trap and rsp_undef are low whenever rsp_valid is low, and they are never high together.
- R2: After reset the control word reads 0x00000002.
- R3: An access at encoding (opc1=4, CRn=1, CRm=1, opc2=0) from EL2 (acc_el=2), or from EL3 (acc_el=3) with acc_ns=1, reads the control word onto rsp_rdata or, with acc_write=1, stores acc_wdata. rsp_rdata is 0 for every other access.
- R4: Bits 31 and 28 of the control word always read 0 and bit 1 always reads 1, whatever value was written.
- R5: An access to the control-word encoding from EL0 or EL1, or from EL3 with acc_ns=0, gives rsp_undef=1 and leaves the stored word unchanged.
- R6: With bit 30 set, reads from non-secure EL1 of the memory-control group trap. With bit 26 set, writes to the same group trap. The group is (opc1,CRn,CRm,opc2): (0,1,0,0), (0,2,0,0), (0,2,0,1), (0,2,0,2), (0,3,0,0), (0,5,0,0), (0,5,0,1), (0,5,1,0), (0,5,1,1), (0,6,0,0), (0,6,0,2), (0,10,2,0), (0,10,2,1), (0,10,3,0), (0,10,3,1) and (0,13,0,1).
- R7: With bit 20 set, any opc1 and opc2 together with CRn=9 and CRm in {0,1,2,5,6,7,8}, CRn=10 and CRm in {0,1,4,8}, or CRn=11 and CRm in 0..8 or 15, traps from non-secure EL1 and is undefined from non-secure EL0.
- R8: With bit 18 set, reads from non-secure EL1 with opc1=0 and CRn=0 trap in three cases: CRm in 3..7 with opc2 in {0,1}; CRm=3 with opc2=2; CRm=5 with opc2 in {4,5}.
- R9: With bit 17 set, reads of (0,0,0,1), (1,0,0,0) and (1,0,0,1), and reads or writes of (2,0,0,0), trap from non-secure EL0 or EL1.
- R10: With bit 16 set, reads from non-secure EL1 of (0,0,0,2), (0,0,0,3), (0,0,0,6) and (1,0,0,7) trap.
- R11: With bit 21 set, any access from non-secure EL1 to (0,1,0,1) traps.
- R12: No access traps when acc_ns=0, when acc_el is 2 or 3, or when the control bit that governs it is clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access request is presented this cycle |
| acc_opc1 | input | 3 | Access encoding, first opcode field |
| acc_crn | input | 4 | Access encoding, primary register number |
| acc_crm | input | 4 | Access encoding, secondary register number |
| acc_opc2 | input | 3 | Access encoding, second opcode field |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_el | input | 2 | Exception level of the requester (0 to 3) |
| acc_ns | input | 1 | Requester is in non-secure state |
| acc_wdata | input | 32 | Write data for the control word |
| rsp_valid | output | 1 | Verdict for the previous cycle's access |
| rsp_trap | output | 1 | Access is sent to the hypervisor |
| rsp_undef | output | 1 | Access raises an undefined-instruction fault |
| rsp_rdata | output | 32 | Control word on a permitted read, else 0 |

## Verification
The hardest case to reach from the ports is an access that uses a control value written in the cycle just before it. A verdict is registered from the word as it stood when the request arrived, so a stale-value bug only shows when a write and a dependent access are issued back to back. The stimulus writes each single trap bit from EL2 and, in the next cycle with no idle gap, issues accesses that sit just inside and just outside that bit's encoding ranges, from both EL0 and EL1 and from both security states. The reserved and forced bits are reached by writing all ones and then all zeros, from the two levels that are allowed to write.

// File: rtl/sysreg_trap_pkg.sv
package sysreg_trap_pkg;

    localparam int CFG_W = 32;
    localparam int EL_W  = 2;

    // control-word bit positions that the decoder reads
    localparam int CB_VMRD  = 30;
    localparam int CB_VMWR  = 26;
    localparam int CB_AUXC  = 21;
    localparam int CB_IMPD  = 20;
    localparam int CB_ID3   = 18;
    localparam int CB_ID2   = 17;
    localparam int CB_ID1   = 16;

    localparam logic [CFG_W-1:0] CFG_ZERO_MASK = 32'h9000_0000;
    localparam logic [CFG_W-1:0] CFG_ONE_MASK  = 32'h0000_0002;
    localparam logic [CFG_W-1:0] CFG_RESET     = CFG_ONE_MASK;

    localparam logic [EL_W-1:0] EL_USR = 2'd0;
    localparam logic [EL_W-1:0] EL_KRN = 2'd1;
    localparam logic [EL_W-1:0] EL_HYP = 2'd2;
    localparam logic [EL_W-1:0] EL_MON = 2'd3;

    typedef struct packed {
        logic [2:0] opc1;
        logic [3:0] crn;
        logic [3:0] crm;
        logic [2:0] opc2;
    } sreg_enc_t;

    typedef struct packed {
        sreg_enc_t       enc;
        logic            wr;
        logic [EL_W-1:0] el;
        logic            ns;
    } acc_t;

    typedef struct packed {
        logic trap;
        logic undef;
    } verdict_t;

    function automatic sreg_enc_t mk(logic [2:0] o1, logic [3:0] n,
                                     logic [3:0] m, logic [2:0] o2);
        sreg_enc_t r;
        r.opc1 = o1; r.crn = n; r.crm = m; r.opc2 = o2;
        return r;
    endfunction

    function automatic logic is_cfg_reg(sreg_enc_t e);
        return e == mk(3'd4, 4'd1, 4'd1, 3'd0);
    endfunction

    function automatic logic cfg_access_ok(logic [EL_W-1:0] el, logic ns);
        return (el == EL_HYP) || (el == EL_MON && ns);
    endfunction

    function automatic logic in_vmctl(sreg_enc_t e);
        return e == mk(3'd0, 4'd1,  4'd0, 3'd0) || e == mk(3'd0, 4'd2,  4'd0, 3'd0) ||
               e == mk(3'd0, 4'd2,  4'd0, 3'd1) || e == mk(3'd0, 4'd2,  4'd0, 3'd2) ||
               e == mk(3'd0, 4'd3,  4'd0, 3'd0) || e == mk(3'd0, 4'd5,  4'd0, 3'd0) ||
               e == mk(3'd0, 4'd5,  4'd0, 3'd1) || e == mk(3'd0, 4'd5,  4'd1, 3'd0) ||
               e == mk(3'd0, 4'd5,  4'd1, 3'd1) || e == mk(3'd0, 4'd6,  4'd0, 3'd0) ||
               e == mk(3'd0, 4'd6,  4'd0, 3'd2) || e == mk(3'd0, 4'd10, 4'd2, 3'd0) ||
               e == mk(3'd0, 4'd10, 4'd2, 3'd1) || e == mk(3'd0, 4'd10, 4'd3, 3'd0) ||
               e == mk(3'd0, 4'd10, 4'd3, 3'd1) || e == mk(3'd0, 4'd13, 4'd0, 3'd1);
    endfunction

    function automatic logic in_impdef(sreg_enc_t e);
        unique case (e.crn)
            4'd9:  return e.crm inside {4'd0, 4'd1, 4'd2, 4'd5, 4'd6, 4'd7, 4'd8};
            4'd10: return e.crm inside {4'd0, 4'd1, 4'd4, 4'd8};
            4'd11: return (e.crm <= 4'd8) || (e.crm == 4'd15);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic in_id3(sreg_enc_t e);
        if (e.opc1 != 3'd0 || e.crn != 4'd0) return 1'b0;
        return ((e.crm >= 4'd3 && e.crm <= 4'd7) && (e.opc2 <= 3'd1)) ||
               (e.crm == 4'd3 && e.opc2 == 3'd2) ||
               (e.crm == 4'd5 && (e.opc2 == 3'd4 || e.opc2 == 3'd5));
    endfunction

    function automatic logic in_id2_rd(sreg_enc_t e);
        return e == mk(3'd0, 4'd0, 4'd0, 3'd1) || e == mk(3'd1, 4'd0, 4'd0, 3'd0) ||
               e == mk(3'd1, 4'd0, 4'd0, 3'd1);
    endfunction

    function automatic logic is_csize_sel(sreg_enc_t e);
        return e == mk(3'd2, 4'd0, 4'd0, 3'd0);
    endfunction

    function automatic logic in_id1(sreg_enc_t e);
        return e == mk(3'd0, 4'd0, 4'd0, 3'd2) || e == mk(3'd0, 4'd0, 4'd0, 3'd3) ||
               e == mk(3'd0, 4'd0, 4'd0, 3'd6) || e == mk(3'd1, 4'd0, 4'd0, 3'd7);
    endfunction

    function automatic logic is_auxctl(sreg_enc_t e);
        return e == mk(3'd0, 4'd1, 4'd0, 3'd1);
    endfunction

endpackage

// File: rtl/trap_cfg_reg.sv
module trap_cfg_reg
    import sysreg_trap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  acc_t             acc,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] cfg_q,
    output logic             rd_hit
);
    logic hit_ok;
    logic wr_en;

    assign hit_ok = acc_valid && is_cfg_reg(acc.enc) && cfg_access_ok(acc.el, acc.ns);
    assign wr_en  = hit_ok && acc.wr;
    assign rd_hit = hit_ok && !acc.wr;

    always_ff @(posedge clk) begin
        if (rst)        cfg_q <= CFG_RESET;
        else if (wr_en) cfg_q <= (wdata & ~CFG_ZERO_MASK) | CFG_ONE_MASK;
    end

    // R5: without a permitted write the stored word does not move
    p_hold_without_write_r5: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(cfg_q));

endmodule

// File: rtl/trap_classify.sv
module trap_classify
    import sysreg_trap_pkg::*;
(
    input  acc_t             acc,
    input  logic [CFG_W-1:0] cfg,
    output verdict_t         verdict
);
    logic guest, at_krn, at_usr, rd;
    logic cfg_bad, impd_usr;
    logic t_vm, t_impd, t_id3, t_id2, t_id1, t_aux;

    always_comb begin
        guest  = acc.ns && (acc.el == EL_USR || acc.el == EL_KRN);
        at_krn = guest && acc.el == EL_KRN;
        at_usr = guest && acc.el == EL_USR;
        rd     = !acc.wr;

        cfg_bad  = is_cfg_reg(acc.enc) && !cfg_access_ok(acc.el, acc.ns);
        impd_usr = at_usr && cfg[CB_IMPD] && in_impdef(acc.enc);

        t_vm   = at_krn && in_vmctl(acc.enc) &&
                 ((rd && cfg[CB_VMRD]) || (acc.wr && cfg[CB_VMWR]));
        t_impd = at_krn && cfg[CB_IMPD] && in_impdef(acc.enc);
        t_id3  = at_krn && rd && cfg[CB_ID3] && in_id3(acc.enc);
        t_id2  = guest && cfg[CB_ID2] &&
                 ((rd && in_id2_rd(acc.enc)) || is_csize_sel(acc.enc));
        t_id1  = at_krn && rd && cfg[CB_ID1] && in_id1(acc.enc);
        t_aux  = at_krn && cfg[CB_AUXC] && is_auxctl(acc.enc);

        verdict.undef = cfg_bad || impd_usr;
        verdict.trap  = !verdict.undef &&
                        (t_vm || t_impd || t_id3 || t_id2 || t_id1 || t_aux);
    end

endmodule

// File: rtl/guest_sysreg_trap.sv
module guest_sysreg_trap
    import sysreg_trap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic [2:0]       acc_opc1,
    input  logic [3:0]       acc_crn,
    input  logic [3:0]       acc_crm,
    input  logic [2:0]       acc_opc2,
    input  logic             acc_write,
    input  logic [EL_W-1:0]  acc_el,
    input  logic             acc_ns,
    input  logic [CFG_W-1:0] acc_wdata,
    output logic             rsp_valid,
    output logic             rsp_trap,
    output logic             rsp_undef,
    output logic [CFG_W-1:0] rsp_rdata
);
    acc_t             acc;
    logic [CFG_W-1:0] cfg_q;
    logic             rd_hit;
    verdict_t         verdict;

    always_comb begin
        acc.enc = mk(acc_opc1, acc_crn, acc_crm, acc_opc2);
        acc.wr  = acc_write;
        acc.el  = acc_el;
        acc.ns  = acc_ns;
    end

    trap_cfg_reg u_cfg (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc       (acc),
        .wdata     (acc_wdata),
        .cfg_q     (cfg_q),
        .rd_hit    (rd_hit)
    );

    trap_classify u_cls (
        .acc     (acc),
        .cfg     (cfg_q),
        .verdict (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_trap  <= 1'b0;
            rsp_undef <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= acc_valid;
            rsp_trap  <= acc_valid && verdict.trap;
            rsp_undef <= acc_valid && verdict.undef;
            rsp_rdata <= rd_hit ? cfg_q : '0;
        end
    end

    // R1: one response per request, one cycle later
    p_rsp_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> rsp_valid);
    p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !rsp_valid);
    p_flags_need_valid_r1: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> !rsp_trap && !rsp_undef);
    p_single_verdict_r1: assert property (@(posedge clk) disable iff (rst)
        !(rsp_trap && rsp_undef));
    // R12: secure or high-level requesters are never trapped
    p_secure_no_trap_r12: assert property (@(posedge clk) disable iff (rst)
        acc_valid && !acc_ns |=> !rsp_trap);
    p_high_el_no_trap_r12: assert property (@(posedge clk) disable iff (rst)
        acc_valid && acc_el[1] |=> !rsp_trap);

endmodule

// File: tb/tb_guest_sysreg_trap.sv
`timescale 1ns/1ps
module tb_guest_sysreg_trap;

    logic        clk = 1'b0;
    logic        rst;
    logic        acc_valid;
    logic [2:0]  acc_opc1;
    logic [3:0]  acc_crn;
    logic [3:0]  acc_crm;
    logic [2:0]  acc_opc2;
    logic        acc_write;
    logic [1:0]  acc_el;
    logic        acc_ns;
    logic [31:0] acc_wdata;
    logic        rsp_valid, rsp_trap, rsp_undef;
    logic [31:0] rsp_rdata;

    always #2 clk = ~clk;   // 250 MHz

    guest_sysreg_trap dut (
        .clk(clk), .rst(rst), .acc_valid(acc_valid),
        .acc_opc1(acc_opc1), .acc_crn(acc_crn), .acc_crm(acc_crm), .acc_opc2(acc_opc2),
        .acc_write(acc_write), .acc_el(acc_el), .acc_ns(acc_ns), .acc_wdata(acc_wdata),
        .rsp_valid(rsp_valid), .rsp_trap(rsp_trap), .rsp_undef(rsp_undef),
        .rsp_rdata(rsp_rdata)
    );

    typedef struct {
        string       tag;
        logic        trap;
        logic        undef;
        logic [31:0] rdata;
    } exp_t;

    exp_t exp_q[$];
    int   checks   = 0;
    int   failures = 0;
    bit   done     = 1'b0;

    // drive one request at a falling edge and queue its expected verdict
    task automatic issue(string tag, logic [1:0] el, logic ns, logic wr,
                         logic [2:0] o1, logic [3:0] n, logic [3:0] m, logic [2:0] o2,
                         logic [31:0] wd, logic et, logic eu, logic [31:0] erd);
        exp_t e;
        acc_valid = 1'b1; acc_el = el; acc_ns = ns; acc_write = wr;
        acc_opc1 = o1; acc_crn = n; acc_crm = m; acc_opc2 = o2; acc_wdata = wd;
        e.tag = tag; e.trap = et; e.undef = eu; e.rdata = erd;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic set_cfg(logic [31:0] v);
        issue("R3 cfg write", 2'd2, 1'b1, 1'b1, 3'd4, 4'd1, 4'd1, 3'd0, v, 1'b0, 1'b0, 32'h0);
    endtask

    task automatic idle(int n);
        acc_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare each response with the head of the queue
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R1 unexpected response: actual valid=1 expected valid=0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (rsp_trap !== e.trap || rsp_undef !== e.undef || rsp_rdata !== e.rdata) begin
                    failures++;
                    $display("FAIL %s: actual trap=%0b undef=%0b rdata=%h expected trap=%0b undef=%0b rdata=%h",
                             e.tag, rsp_trap, rsp_undef, rsp_rdata, e.trap, e.undef, e.rdata);
                end
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; acc_valid = 1'b0; acc_opc1 = '0; acc_crn = '0; acc_crm = '0;
        acc_opc2 = '0; acc_write = 1'b0; acc_el = '0; acc_ns = 1'b0; acc_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;   // R1 reset state
        if (rsp_valid !== 1'b0 || rsp_trap !== 1'b0 || rsp_undef !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: actual valid=%0b trap=%0b undef=%0b expected 0 0 0",
                     rsp_valid, rsp_trap, rsp_undef);
        end

        // R2, R3, R4, R5: the control word itself
        issue("R2 reset value", 2'd2, 1'b1, 1'b0, 3'd4, 4'd1, 4'd1, 3'd0, 32'h0, 1'b0, 1'b0, 32'h0000_0002);
        issue("R3 write all ones", 2'd2, 1'b1, 1'b1, 3'd4, 4'd1, 4'd1, 3'd0, 32'hFFFF_FFFF, 1'b0, 1'b0, 32'h0);
        issue("R4 reserved bits", 2'd2, 1'b1, 1'b0, 3'd4, 4'd1, 4'd1, 3'd0, 32'h0, 1'b0, 1'b0, 32'h6FFF_FFFF);
        issue("R5 EL1 write undef", 2'd1, 1'b1, 1'b1, 3'd4, 4'd1, 4'd1, 3'd0, 32'h0, 1'b0, 1'b1, 32'h0);
        issue("R5 EL0 read undef", 2'd0, 1'b1, 1'b0, 3'd4, 4'd1, 4'd1, 3'd0, 32'h0, 1'b0, 1'b1, 32'h0);
        issue("R5 secure monitor undef", 2'd3, 1'b0, 1'b1, 3'd4, 4'd1, 4'd1, 3'd0, 32'h0, 1'b0, 1'b1, 32'h0);
        issue("R5 value kept", 2'd2, 1'b1, 1'b0, 3'd4, 4'd1, 4'd1, 3'd0, 32'h0, 1'b0, 1'b0, 32'h6FFF_FFFF);
        issue("R3 monitor write", 2'd3, 1'b1, 1'b1, 3'd4, 4'd1, 4'd1, 3'd0, 32'h4000_0000, 1'b0, 1'b0, 32'h0);
        issue("R4 bit1 forced", 2'd3, 1'b1, 1'b0, 3'd4, 4'd1, 4'd1, 3'd0, 32'h0, 1'b0, 1'b0, 32'h4000_0002);

        // R6: memory-control group, read side (bit 30 set now)
        issue("R6 vm read trap", 2'd1, 1'b1, 1'b0, 3'd0, 4'd1, 4'd0, 3'd0, 32'h0, 1'b1, 1'b0, 32'h0);
        issue("R6 vm write passes", 2'd1, 1'b1, 1'b1, 3'd0, 4'd1, 4'd0, 3'd0, 32'h0, 1'b0, 1'b0, 32'h0);
        issue("R6 last member read trap", 2'd1, 1'b1, 1'b0, 3'd0, 4'd13, 4'd0, 3'd1, 32'h0, 1'b1, 1'b0, 32'h0);
        issue("R12 secure no trap", 2'd1, 1'b0, 1'b0, 3'd0, 4'd1, 4'd0, 3'd0, 32'h0, 1'b0, 1'b0, 32'h0);
        issue("R12 EL2 no trap", 2'd2, 1'b1, 1'b0, 3'd0, 4'd1, 4'd0, 3'd0, 32'h0, 1'b0, 1'b0, 32'h0);
        set_cfg(32'h0400_0000);
        issue("R6 vm write trap", 2'd1, 1'b1, 1'b1, 3'd0, 4'd2, 4'd0, 3'd2, 32'h0, 1'b1, 1'b0, 32'h0);
        issue("R6 vm read passes", 2'd1, 1'b1, 1'b0, 3'd0, 4'd2, 4'd0, 3'd2, 32'h0, 1'b0, 1'b0, 32'h0);

        // R7: implementation-defined ranges
        set_cfg(32'h0010_0000);
        issue("R7 c9 in range", 2'd1, 1'b1, 1'b0, 3'd3, 4'd9, 4'd5, 3'd7, 32'h0, 1'b1, 1'b0, 32'h0);
        issue("R7 c9 gap", 2'd1, 1'b1, 1'b0, 3'd0, 4'd9, 4'd3, 3'd0, 32'h0, 1'b0, 1'b0, 32'h0);
        issue("R7 c10 in range", 2'd1, 1'b1, 1'b1, 3'd0, 4'd10, 4'd4, 3'd0, 32'h0, 1'b1, 1'b0, 32'h0);
        issue("R7 c10 gap", 2'd1, 1'b1, 1'b0, 3'd0, 4'd10, 4'd2, 3'd0, 32'h0, 1'b0, 1'b0, 32'h0);
        issue("R7 c11 crm15", 2'd1, 1'b1, 1'b0, 3'd7, 4'd11, 4'd15, 3'd1, 32'h0, 1'b1, 1'b0, 32'h0);
        issue("R7 c11 crm9", 2'd1, 1'b1, 1'b0, 3'd0, 4'd11, 4'd9, 3'd0, 32'h0, 1'b0, 1'b0, 32'h0);
        issue("R7 EL0 undef", 2'd0, 1'b1, 1'b0, 3'd0, 4'd11, 4'd0, 3'd0, 32'h0, 1'b0, 1'b1, 32'h0);
        issue("R7 secure passes", 2'd1, 1'b0, 1'b0, 3'd0, 4'd9, 4'd0, 3'd0, 32'h0, 1'b0, 1'b0, 32'h0);

        // R8: ID group 3
        set_cfg(32'h0004_0000);
        issue("R8 crm3 opc2=2", 2'd1, 1'b1, 1'b0, 3'd0, 4'd0, 4'd3, 3'd2, 32'h0, 1'b1, 1'b0, 32'h0);
        issue("R8 crm5 opc2=4", 2'd1, 1'b1, 1'b0, 3'd0, 4'd0, 4'd5, 3'd4, 32'h0, 1'b1, 1'b0, 32'h0);
        issue("R8 crm7 opc2=1", 2'd1, 1'b1, 1'b0, 3'd0, 4'd0, 4'd7, 3'd1, 32'h0, 1'b1, 1'b0, 32'h0);
        issue("R8 crm6 opc2=2", 2'd1, 1'b1, 1'b0, 3'd0, 4'd0, 4'd6, 3'd2, 32'h0, 1'b0, 1'b0, 32'h0);
        issue("R8 write passes", 2'd1, 1'b1, 1'b1, 3'd0, 4'd0, 4'd3, 3'd0, 32'h0, 1'b0, 1'b0, 32'h0);
        issue("R8 opc1=1 passes", 2'd1, 1'b1, 1'b0, 3'd1, 4'd0, 4'd3, 3'd0, 32'h0, 1'b0, 1'b0, 32'h0);
        issue("R8 EL0 passes", 2'd0, 1'b1, 1'b0, 3'd0, 4'd0, 4'd3, 3'd0, 32'h0, 1'b0, 1'b0, 32'h0);

        // R9: cache ID group
        set_cfg(32'h0002_0000);
        issue("R9 EL0 size read", 2'd0, 1'b1, 1'b0, 3'd1, 4'd0, 4'd0, 3'd0, 32'h0, 1'b1, 1'b0, 32'h0);
        issue("R9 selector write", 2'd1, 1'b1, 1'b1, 3'd2, 4'd0, 4'd0, 3'd0, 32'h0, 1'b1, 1'b0, 32'h0);
        issue("R9 type read", 2'd1, 1'b1, 1'b0, 3'd0, 4'd0, 4'd0, 3'd1, 32'h0, 1'b1, 1'b0, 32'h0);
        issue("R9 type write passes", 2'd1, 1'b1, 1'b1, 3'd0, 4'd0, 4'd0, 3'd1, 32'h0, 1'b0, 1'b0, 32'h0);

        // R10: ID group 1
        set_cfg(32'h0001_0000);
        issue("R10 revision read", 2'd1, 1'b1, 1'b0, 3'd0, 4'd0, 4'd0, 3'd6, 32'h0, 1'b1, 1'b0, 32'h0);
        issue("R10 aux id read", 2'd1, 1'b1, 1'b0, 3'd1, 4'd0, 4'd0, 3'd7, 32'h0, 1'b1, 1'b0, 32'h0);
        issue("R10 EL0 passes", 2'd0, 1'b1, 1'b0, 3'd0, 4'd0, 4'd0, 3'd6, 32'h0, 1'b0, 1'b0, 32'h0);
        issue("R10 other group passes", 2'd1, 1'b1, 1'b0, 3'd0, 4'd0, 4'd0, 3'd1, 32'h0, 1'b0, 1'b0, 32'h0);

        // R11: auxiliary control
        set_cfg(32'h0020_0000);
        issue("R11 write trap", 2'd1, 1'b1, 1'b1, 3'd0, 4'd1, 4'd0, 3'd1, 32'h0, 1'b1, 1'b0, 32'h0);
        issue("R11 read trap", 2'd1, 1'b1, 1'b0, 3'd0, 4'd1, 4'd0, 3'd1, 32'h0, 1'b1, 1'b0, 32'h0);
        issue("R11 EL0 passes", 2'd0, 1'b1, 1'b0, 3'd0, 4'd1, 4'd0, 3'd1, 32'h0, 1'b0, 1'b0, 32'h0);
        issue("R11 secure passes", 2'd1, 1'b0, 1'b0, 3'd0, 4'd1, 4'd0, 3'd1, 32'h0, 1'b0, 1'b0, 32'h0);

        // R12: all bits clear
        set_cfg(32'h0000_0000);
        issue("R12 vm read clear", 2'd1, 1'b1, 1'b0, 3'd0, 4'd1, 4'd0, 3'd0, 32'h0, 1'b0, 1'b0, 32'h0);
        issue("R12 impdef EL0 clear", 2'd0, 1'b1, 1'b0, 3'd0, 4'd9, 4'd0, 3'd0, 32'h0, 1'b0, 1'b0, 32'h0);
        issue("R4 zero write", 2'd2, 1'b1, 1'b0, 3'd4, 4'd1, 4'd1, 3'd0, 32'h0, 1'b0, 1'b0, 32'h0000_0002);

        idle(4);
        checks++;   // R1 every request answered
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R1 missing responses: actual pending=%0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule